// File: doc/BRIEF.md
# Bus ROM search step controller

This block carries out a single decision step of the ROM search on a single-wire open-drain bus. A start strobe launches three time slots on the wire. Two read slots come first: the first returns the addressed bit of every responding device, and the second returns its complement. The block then picks a branch direction and sends it back in a write slot. The bits the devices returned, plus the direction taken, come out as a packed 3-bit status together with a one-cycle done pulse.

A search controller calls this block once per ROM bit and passes in the direction it prefers for that bit. The controller keeps the discrepancy bookkeeping across all 64 bits and sends the search command itself.

The wire is modelled as an open-drain line. The block drives `bus_pull` high to pull the line low and reads the resolved level on `bus_in`. All slot timings are parameters counted in clock cycles.

Top module: `ow_search_step`

## Requirements
- R1: After a start, the block runs two read slots back to back, each `T_SLOT` cycles long. Each read slot pulls the line low for `T_LOW_SHORT` cycles, then releases it and samples `bus_in` at cycle `T_SAMPLE-1` of the slot. The first sample is the id bit and the second is the complement bit.
- R2: If both sampled bits are 1, the step ends with no write slot. The status is 3'b011, and done follows the end of the second read slot.
- R3: If both sampled bits are 0, the direction is the preferred direction captured at start. The status is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R4: If exactly one sampled bit is 1, the direction is forced to the id bit. The status is 3'b101 when the id bit is 1 and 3'b010 otherwise.
- R5: Status bit 0 carries the id bit, bit 1 the complement bit and bit 2 the direction taken.
- R6: In every case except R2, a third slot writes the direction. A 1 is sent as a low pulse of `T_LOW_SHORT` cycles and a 0 as a low pulse of `T_LOW_LONG` cycles, both inside a slot of `T_SLOT` cycles.
- R7: Done is high for exactly one cycle. It rises on the cycle after the last slot ends, so a step takes 3·`T_SLOT` or 2·`T_SLOT` cycles from start to done. Status holds its value until the next done.
- R8: The preferred direction is captured on the start cycle. Changes on `pref_dir` during a step have no effect.
- R9: A start that arrives while a step is in progress is ignored. It adds no slot and does not restart the step.
- R10: After reset, the line is released, done is low and status is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one search step when idle |
| pref_dir | input | 1 | Direction to take when both read bits are 0 |
| bus_in | input | 1 | Resolved line level (1 = released high) |
| bus_pull | output | 1 | 1 pulls the open-drain line low |
| status | output | 3 | {direction, complement bit, id bit} of the last step |
| done | output | 1 | One-cycle pulse at the end of a step |

## Verification
The assertions assume that `start` is only acted on while idle and that `bus_in` is a well-defined level at each sample point. They make no assumption about when the devices release the line. The bench's device model holds the line low for longer than `T_SAMPLE` whenever it answers a 0, and releases it well before the slot ends, so every sample sees a settled level. Starts that arrive mid-step and toggles of `pref_dir` are placed deliberately inside an active step, to exercise the capture and ignore rules.

// File: rtl/ow_search_step.sv
module ow_search_step #(
  parameter int T_SLOT      = 70,
  parameter int T_LOW_SHORT = 6,
  parameter int T_LOW_LONG  = 60,
  parameter int T_SAMPLE    = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pref_dir,
  input  logic       bus_in,
  output logic       bus_pull,
  output logic [2:0] status,
  output logic       done
);
  localparam int CW = $clog2(T_SLOT + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD_ID, S_RD_CMP, S_WR} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          id_q, cmp_q, dir_q;

  logic active, slot_end, sample_now, long_low;

  assign active     = state != S_IDLE;
  assign slot_end   = cnt == CW'(T_SLOT - 1);
  assign sample_now = cnt == CW'(T_SAMPLE - 1);
  assign long_low   = (state == S_WR) && !dir_q;
  assign bus_pull   = active && (cnt < (long_low ? CW'(T_LOW_LONG) : CW'(T_LOW_SHORT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      dir_q  <= 1'b0;
      status <= 3'b000;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (active) cnt <= slot_end ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          dir_q <= pref_dir;
          cnt   <= '0;
          state <= S_RD_ID;
        end
        S_RD_ID: begin
          if (sample_now) id_q <= bus_in;
          if (slot_end) state <= S_RD_CMP;
        end
        S_RD_CMP: begin
          if (sample_now) cmp_q <= bus_in;
          if (slot_end) begin
            if (id_q && cmp_q) begin
              status <= 3'b011;
              done   <= 1'b1;
              state  <= S_IDLE;
            end else begin
              if (id_q ^ cmp_q) dir_q <= id_q;
              state <= S_WR;
            end
          end
        end
        S_WR: if (slot_end) begin
          status <= {dir_q, cmp_q, id_q};
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module ow_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       active,
  input logic       bus_pull,
  input logic [2:0] status,
  input logic       done
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(active));
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !bus_pull);
  assert_start_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));
  assert_no_both_with_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && status[0] && status[1] |-> !status[2]);
  assert_forced_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status[0] != status[1]) |-> status[2] == status[0]);
  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(status) || done);
endmodule

bind ow_search_step ow_search_step_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .active(active),
  .bus_pull(bus_pull), .status(status), .done(done)
);

// File: tb/test_ow_search_step.sv
module test_ow_search_step;
  localparam int CLK_PERIOD  = 10;
  localparam int T_SLOT      = 70;
  localparam int T_LOW_SHORT = 6;
  localparam int T_LOW_LONG  = 60;
  localparam int T_SAMPLE    = 15;
  localparam int HOLD_ZERO   = 30;

  logic clk = 0, rst_n = 0, start = 0, pref_dir = 0;
  logic bus_pull, done, bus_in;
  logic [2:0] status;

  int checks = 0, fails = 0;

  logic dev_id = 1, dev_cmp = 1;
  int   slot_idx = 0, low_cnt = 0, last_low = 0, hold = 0;
  logic prev_pull = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_in = ~(bus_pull | (hold > 0));

  ow_search_step #(.T_SLOT(T_SLOT), .T_LOW_SHORT(T_LOW_SHORT),
                   .T_LOW_LONG(T_LOW_LONG), .T_SAMPLE(T_SAMPLE)) i_ow_search_step (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .bus_in(bus_in), .bus_pull(bus_pull), .status(status), .done(done));

  // device model: answers read slots, measures low pulse widths
  always @(negedge clk) begin
    if (hold > 0) hold = hold - 1;
    if (bus_pull && !prev_pull) begin
      if ((slot_idx % 3 == 0 && !dev_id) || (slot_idx % 3 == 1 && !dev_cmp)) hold = HOLD_ZERO;
      slot_idx = slot_idx + 1;
      low_cnt = 0;
    end
    if (bus_pull) low_cnt = low_cnt + 1;
    if (!bus_pull && prev_pull) last_low = low_cnt;
    prev_pull = bus_pull;
  end

  function automatic logic [2:0] exp_status(logic id, logic cmp, logic pref);
    if (id && cmp) return 3'b011;
    if (!id && !cmp) return pref ? 3'b100 : 3'b000;
    return id ? 3'b101 : 3'b010;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(logic id, logic cmp, logic pref, logic flip, logic poke);
    int k, base, nslots;
    logic [2:0] e;
    e = exp_status(id, cmp, pref);
    nslots = (id && cmp) ? 2 : 3;
    slot_idx = 0;
    dev_id = id; dev_cmp = cmp;
    @(negedge clk);
    base = slot_idx;
    pref_dir = pref; start = 1;
    @(negedge clk);
    start = 0; k = 1;
    while (!done && k < 4*T_SLOT) begin
      if (flip && k == 5) pref_dir = ~pref;
      if (poke && k == T_SLOT + 3) start = 1;
      else start = 0;
      @(negedge clk); k++;
    end
    start = 0;
    check("R7 cycles to done", k, nslots*T_SLOT + 1);
    check("R5 status", int'(status), int'(e));
    check("R1 R2 R9 slot count", slot_idx - base, nslots);
    if (nslots == 3)
      check("R6 write low width", last_low, e[2] ? T_LOW_SHORT : T_LOW_LONG);
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 status held", int'(status), int'(e));
    check("R9 no extra slot", slot_idx - base, nslots);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    check("R10 reset pull", int'(bus_pull), 0);
    check("R10 reset done", int'(done), 0);
    check("R10 reset status", int'(status), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R10 idle pull", int'(bus_pull), 0);
    // directed: all combinations (R2 R3 R4)
    for (int c = 0; c < 8; c++) run_op(c[0], c[1], c[2], 1'b0, 1'b0);
    // R8: pref flips mid-step
    run_op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9: start during a step
    run_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    run_op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    // random mix
    for (int n = 0; n < 24; n++)
      run_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule